// File: doc/BRIEF.md
# Start-Gap Row Remapper

This block sits between a host request stream and a non-volatile memory bank and turns each logical row address into a physical row address. The bank has one more physical row than there are logical rows. One physical row, the gap, holds no live data at any time. A start offset and the gap position together define the current mapping. The block counts accepted host writes. After every `GAP_INTERVAL` of them it moves the gap down by one row. To do so it has an external row mover copy the neighbouring row into the gap. Over many moves, every logical row travels across every physical row, which spreads the write wear.

A translated request leaves the block one cycle after the block accepts it. The read/write flag and the byte offset inside the row pass through unchanged. While a row copy is outstanding, the block holds `req_ready` low, so that no request ever sees a half-moved row.

The control is a two-state machine:
- `ST_SERVE`: requests are accepted and no copy is pending. It moves to `ST_MOVE` on the accepted write that completes an interval.
- `ST_MOVE`: a copy command is presented. It returns to `ST_SERVE` in the cycle `copy_done` is seen, and in that same cycle the start and gap registers are updated.

Top module: `sg_remap`

## Requirements
- R1: After reset, `req_ready` is 1 and both `out_valid` and `copy_valid` are 0. The mapping starts as the identity: start 0, gap at row `ROWS`.
- R2: A request is accepted in any cycle in which `req_valid` and `req_ready` are both 1. One cycle later, `out_valid` is 1 for exactly one cycle, and `out_write` and `out_ofs` equal the accepted values. In every other cycle, `out_valid` is 0.
- R3: Only accepted writes (`req_write`=1) advance the interval count. Any number of reads never raises `copy_valid`.
- R4: A move with gap g > 0 copies source row g-1 into destination row g. When it completes, the gap becomes g-1.
- R5: A move with gap 0 copies source row `ROWS` into destination row 0. When it completes, the gap becomes `ROWS` and start becomes (start+1) mod `ROWS`.
- R6: The accepted write that completes an interval of `GAP_INTERVAL` writes puts the block in `ST_MOVE` from the next cycle. In that state `req_ready` is 0 and no request is accepted. The block returns to `ST_SERVE` (`req_ready` = 1) in the cycle after `copy_done` is seen high.
- R7: In `ST_MOVE`, `copy_valid` stays 1 and `copy_src`/`copy_dst` stay constant until `copy_done` is 1.
- R8: The physical row is r = (logical + start) mod `ROWS`, plus one when r ≥ gap. The write that triggers a move is translated with the mapping from before that move.
- R9: A translated row never equals the current gap row and never exceeds `ROWS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | LROW_W | Logical row, below ROWS |
| req_ofs | input | OFS_W | Byte offset inside the row |
| out_valid | output | 1 | Translated request present |
| out_write | output | 1 | Passed-through write flag |
| out_row | output | PROW_W | Physical row |
| out_ofs | output | OFS_W | Passed-through byte offset |
| copy_valid | output | 1 | Row copy requested |
| copy_src | output | PROW_W | Physical row to read |
| copy_dst | output | PROW_W | Physical row to write |
| copy_done | input | 1 | Row copy finished |

## Verification
The bench concentrates on three corners:
- **Gap-zero wrap.** A design that got it wrong would copy from a row that does not exist, or would fail to advance start. Every logical row would then come out one row off after the wrap.
- **The write that completes an interval.** An off-by-one in the count would move the gap one write early or late. A translation taken after the update would send that write to the already-moved mapping.
- **Requests held high while a copy is in flight, and the copy-done handshake at zero and at several cycles of latency.** A leaky ready signal would produce output pulses during the copy, and an early state return would drop the command.

A non-power-of-two row count exercises the modulo step.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic [0:0] {
        ST_SERVE = 1'b0,
        ST_MOVE  = 1'b1
    } sg_state_e;
endpackage

// File: rtl/sg_xlate.sv
module sg_xlate #(
    parameter int ROWS   = 16,
    parameter int LROW_W = $clog2(ROWS),
    parameter int PROW_W = $clog2(ROWS + 1)
) (
    input  logic [LROW_W-1:0] lrow,
    input  logic [LROW_W-1:0] start,
    input  logic [PROW_W-1:0] gap,
    output logic [PROW_W-1:0] prow
);
    localparam int SUM_W = PROW_W + 1;
    localparam logic [SUM_W-1:0] ROWS_S = SUM_W'(ROWS);

    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  wrapped;
    logic [PROW_W-1:0] rot;

    always_comb begin
        sum     = SUM_W'(lrow) + SUM_W'(start);
        wrapped = (sum >= ROWS_S) ? (sum - ROWS_S) : sum;
        rot     = wrapped[PROW_W-1:0];
        prow    = (rot >= gap) ? (rot + PROW_W'(1)) : rot;
    end
endmodule

// File: rtl/sg_wcount.sv
module sg_wcount #(
    parameter int GAP_INTERVAL = 128,
    parameter int CNT_W        = (GAP_INTERVAL > 2) ? $clog2(GAP_INTERVAL) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_acc,
    output logic trig
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP_INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;

    assign trig = wr_acc && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_acc) begin
            cnt_q <= trig ? '0 : (cnt_q + CNT_W'(1));
        end
    end
endmodule

// File: rtl/sg_ptrs.sv
module sg_ptrs #(
    parameter int ROWS   = 16,
    parameter int LROW_W = $clog2(ROWS),
    parameter int PROW_W = $clog2(ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              move,
    output logic [LROW_W-1:0] start_q,
    output logic [PROW_W-1:0] gap_q,
    output logic [PROW_W-1:0] src,
    output logic [PROW_W-1:0] dst
);
    localparam logic [PROW_W-1:0] TOP_ROW    = PROW_W'(ROWS);
    localparam logic [LROW_W-1:0] LAST_START = LROW_W'(ROWS - 1);

    logic at_bottom;

    assign at_bottom = (gap_q == '0);

    always_comb begin
        if (at_bottom) begin
            src = TOP_ROW;
            dst = '0;
        end else begin
            src = gap_q - PROW_W'(1);
            dst = gap_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            gap_q   <= TOP_ROW;
        end else if (move) begin
            if (at_bottom) begin
                gap_q   <= TOP_ROW;
                start_q <= (start_q == LAST_START) ? '0 : (start_q + LROW_W'(1));
            end else begin
                gap_q <= gap_q - PROW_W'(1);
            end
        end
    end
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
    import sg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic copy_done,
    output logic req_ready,
    output logic copy_valid,
    output logic move
);
    sg_state_e state_q;
    sg_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SERVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SERVE: if (trig)      state_d = ST_MOVE;
            ST_MOVE:  if (copy_done) state_d = ST_SERVE;
            default:                 state_d = ST_SERVE;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        copy_valid = 1'b0;
        move       = 1'b0;
        unique case (state_q)
            ST_SERVE: req_ready = 1'b1;
            ST_MOVE: begin
                copy_valid = 1'b1;
                move       = copy_done;
            end
            default: req_ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/sg_remap.sv
module sg_remap #(
    parameter int ROWS         = 16,
    parameter int GAP_INTERVAL = 128,
    parameter int OFS_W        = 12,
    parameter int LROW_W       = $clog2(ROWS),
    parameter int PROW_W       = $clog2(ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [LROW_W-1:0] req_row,
    input  logic [OFS_W-1:0]  req_ofs,
    output logic              out_valid,
    output logic              out_write,
    output logic [PROW_W-1:0] out_row,
    output logic [OFS_W-1:0]  out_ofs,
    output logic              copy_valid,
    output logic [PROW_W-1:0] copy_src,
    output logic [PROW_W-1:0] copy_dst,
    input  logic              copy_done
);
    logic              acc;
    logic              wr_acc;
    logic              trig;
    logic              move;
    logic [LROW_W-1:0] start_q;
    logic [PROW_W-1:0] gap_q;
    logic [PROW_W-1:0] prow;

    assign acc    = req_valid && req_ready;
    assign wr_acc = acc && req_write;

    sg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .copy_done  (copy_done),
        .req_ready  (req_ready),
        .copy_valid (copy_valid),
        .move       (move)
    );

    sg_wcount #(.GAP_INTERVAL(GAP_INTERVAL)) u_wcount (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_acc (wr_acc),
        .trig   (trig)
    );

    sg_ptrs #(.ROWS(ROWS), .LROW_W(LROW_W), .PROW_W(PROW_W)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .move    (move),
        .start_q (start_q),
        .gap_q   (gap_q),
        .src     (copy_src),
        .dst     (copy_dst)
    );

    sg_xlate #(.ROWS(ROWS), .LROW_W(LROW_W), .PROW_W(PROW_W)) u_xlate (
        .lrow  (req_row),
        .start (start_q),
        .gap   (gap_q),
        .prow  (prow)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_write <= 1'b0;
            out_row   <= '0;
            out_ofs   <= '0;
        end else begin
            out_valid <= acc;
            if (acc) begin
                out_write <= req_write;
                out_row   <= prow;
                out_ofs   <= req_ofs;
            end
        end
    end
endmodule

// File: rtl/sg_remap_chk.sv
module sg_remap_chk #(
    parameter int ROWS   = 16,
    parameter int OFS_W  = 12,
    parameter int PROW_W = $clog2(ROWS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [OFS_W-1:0]  req_ofs,
    input logic              out_valid,
    input logic [PROW_W-1:0] out_row,
    input logic [OFS_W-1:0]  out_ofs,
    input logic              copy_valid,
    input logic [PROW_W-1:0] copy_src,
    input logic [PROW_W-1:0] copy_dst,
    input logic              copy_done,
    input logic [PROW_W-1:0] gap_q
);
    // R2
    accept_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (out_valid && out_ofs == $past(req_ofs)));

    // R2
    no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !out_valid);

    // R3
    read_no_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !copy_valid);

    // R6
    ready_low_in_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> !req_ready);

    // R7
    copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_valid && !copy_done) |=> (copy_valid && $stable(copy_src) && $stable(copy_dst)));

    // R4
    copy_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_valid && copy_src != PROW_W'(ROWS)) |-> (copy_dst == copy_src + PROW_W'(1)));

    // R5
    copy_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_valid && copy_src == PROW_W'(ROWS)) |-> (copy_dst == '0));

    // R9
    gap_avoid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_row != gap_q && out_row <= PROW_W'(ROWS)));
endmodule

bind sg_remap sg_remap_chk #(.ROWS(ROWS), .OFS_W(OFS_W), .PROW_W(PROW_W)) u_sg_remap_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_ofs    (req_ofs),
    .out_valid  (out_valid),
    .out_row    (out_row),
    .out_ofs    (out_ofs),
    .copy_valid (copy_valid),
    .copy_src   (copy_src),
    .copy_dst   (copy_dst),
    .copy_done  (copy_done),
    .gap_q      (gap_q)
);

// File: tb/test_sg_remap.sv
module test_sg_remap;
    localparam int ROWS   = 6;
    localparam int GI     = 5;
    localparam int OFS_W  = 12;
    localparam int LROW_W = $clog2(ROWS);
    localparam int PROW_W = $clog2(ROWS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [LROW_W-1:0] req_row = '0;
    logic [OFS_W-1:0]  req_ofs = '0;
    logic              out_valid;
    logic              out_write;
    logic [PROW_W-1:0] out_row;
    logic [OFS_W-1:0]  out_ofs;
    logic              copy_valid;
    logic [PROW_W-1:0] copy_src;
    logic [PROW_W-1:0] copy_dst;
    logic              copy_done = 1'b0;

    int checks = 0;
    int failures = 0;

    // model state
    int m_start = 0;
    int m_gap = ROWS;
    int m_cnt = 0;
    bit m_copy = 0;
    int m_delay = 0;
    bit e_ov = 0;
    int e_row = 0;
    int e_wr = 0;
    int e_ofs = 0;
    int e_gap = 0;
    bit e_trig = 0;
    int wraps = 0;

    always #10 clk = ~clk;

    sg_remap #(.ROWS(ROWS), .GAP_INTERVAL(GI), .OFS_W(OFS_W)) i_sg_remap (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_ofs(req_ofs),
        .out_valid(out_valid), .out_write(out_write), .out_row(out_row), .out_ofs(out_ofs),
        .copy_valid(copy_valid), .copy_src(copy_src), .copy_dst(copy_dst),
        .copy_done(copy_done)
    );

    function automatic int map_row(int l, int s, int g);
        int r;
        r = (l + s) % ROWS;
        return (r >= g) ? r + 1 : r;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input bit w, input int row, input int ofs);
        bit acc;
        bit done;
        // check outputs produced by the previous edge
        check("R2 out_valid", int'(out_valid), int'(e_ov));
        if (e_ov) begin
            check(e_trig ? "R8 out_row" : "R2 out_row", int'(out_row), e_row);
            check("R2 out_write", int'(out_write), e_wr);
            check("R2 out_ofs", int'(out_ofs), e_ofs);
            check("R9 out_row vs gap", int'(out_row != PROW_W'(e_gap)), 1);
        end
        check("R6 req_ready", int'(req_ready), int'(!m_copy));
        check(m_copy ? "R7 copy_valid" : "R3 copy_valid", int'(copy_valid), int'(m_copy));
        if (m_copy) begin
            check(m_gap == 0 ? "R5 copy_src" : "R4 copy_src", int'(copy_src),
                  m_gap == 0 ? ROWS : m_gap - 1);
            check(m_gap == 0 ? "R5 copy_dst" : "R4 copy_dst", int'(copy_dst),
                  m_gap == 0 ? 0 : m_gap);
        end
        // drive
        done = 0;
        if (m_copy) begin
            if (m_delay == 0) done = 1;
            else m_delay--;
        end
        req_valid = v;
        req_write = w;
        req_row   = LROW_W'(row);
        req_ofs   = OFS_W'(ofs);
        copy_done = done;
        // model next edge
        acc = v && !m_copy;
        e_ov = acc;
        e_trig = 0;
        if (acc) begin
            e_row = map_row(row, m_start, m_gap);
            e_wr  = int'(w);
            e_ofs = ofs;
            e_gap = m_gap;
        end
        if (m_copy && done) begin
            if (m_gap == 0) begin
                m_gap = ROWS;
                m_start = (m_start + 1) % ROWS;
                wraps++;
            end else begin
                m_gap--;
            end
            m_copy = 0;
        end else if (acc && w) begin
            m_cnt++;
            if (m_cnt == GI) begin
                m_cnt = 0;
                m_copy = 1;
                m_delay = $urandom_range(0, 3);
                e_trig = 1;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 req_ready", int'(req_ready), 1);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 copy_valid", int'(copy_valid), 0);
        // R1 identity mapping right after reset
        for (int i = 0; i < ROWS; i++) step(1, 0, i, i * 7);
        // R3 long read stream never triggers a move
        for (int i = 0; i < 4 * GI; i++) step(1, 0, i % ROWS, i);
        // R6 keep valid high through moves, writes only
        for (int i = 0; i < 4 * GI * (ROWS + 1); i++) step(1, 1, i % ROWS, i & 12'hfff);
        // mixed random traffic
        for (int i = 0; i < 6000; i++)
            step($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 6,
                 $urandom_range(0, ROWS - 1), $urandom_range(0, 4095));
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        // R5 wrap exercised at least once
        check("R5 wrap count nonzero", int'(wraps > 0), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule